// File: doc/BRIEF.md
# Masked Packed Unsigned Saturating Subtractor

This execution unit takes two packed vectors of unsigned integers and subtracts the second from the first lane by lane. A lane whose true difference would be negative is clamped to zero. The lanes are either 8 or 16 bits wide, and both sizes share one datapath. The active vector length is 64, 128, 256 or 512 bits.

An optional per-lane mask selects which lanes receive the difference. In merge mode an unselected lane keeps its old destination value. In zero mode it is cleared. Destination bits above the active length are either kept from the old value or cleared, under a control input.

Inputs are captured on a cycle with `in_valid` high. The whole result is registered and appears on the next clock edge, with a one-cycle `out_valid` strobe. The 64-bit length models the narrow legacy form. In that form masking and the upper-clear control are ignored, and only bits 63:0 are written.

Top module: `packed_usub_sat`

## Requirements
- R1: In byte mode (`word_lanes`=0), byte lane j occupies bits j*8+7:j*8 and receives `src_a` lane minus `src_b` lane when that difference is zero or positive, and 8'h00 when it is negative.
- R2: In word mode (`word_lanes`=1), lane j occupies bits j*16+15:j*16 and saturates to 16'h0000 on a negative difference. In either mode no borrow crosses a lane boundary: for 16'h0100 minus 16'h0001, byte mode gives 16'h0100 and word mode gives 16'h00FF.
- R3: `vlen_sel` encodes the active length as 0=64, 1=128, 2=256, 3=512 bits. Only lanes that lie wholly below the active length are computed.
- R4: With `mask_en`=0, or with a lane's mask bit equal to 1, an active lane receives its saturated difference. Bit j of `lane_mask` governs lane j.
- R5: With `mask_en`=1, `mask_zero`=0 and the lane's mask bit at 0, an active lane in a length other than 64 bits takes its value from `dest_old`.
- R6: With `mask_en`=1, `mask_zero`=1 and the lane's mask bit at 0, an active lane in a length other than 64 bits is written with zero.
- R7: For lengths other than 64 bits, bits from the active length up to 511 are zero when `upper_clear`=1 and equal to `dest_old` when `upper_clear`=0.
- R8: At the 64-bit length, `mask_en`, `lane_mask`, `mask_zero` and `upper_clear` have no effect. All 8 byte or 4 word lanes get the difference, and bits 511:64 equal `dest_old`.
- R9: Mask bits at or above the active lane count have no effect on `result`.
- R10: `result` and `out_valid`=1 appear on the first rising edge after `in_valid` is sampled high. `out_valid` is low after any cycle without `in_valid`. `result` holds its value while `in_valid` is low. A rising edge with `rst_n` low clears both `out_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs are captured this cycle |
| src_a | input | 512 | Minuend vector |
| src_b | input | 512 | Subtrahend vector |
| dest_old | input | 512 | Previous destination value, used for merging and kept upper bits |
| lane_mask | input | 64 | Per-lane select, bit j for lane j |
| word_lanes | input | 1 | 0 = 8-bit lanes, 1 = 16-bit lanes |
| vlen_sel | input | 2 | Active length: 0=64, 1=128, 2=256, 3=512 bits |
| mask_en | input | 1 | Apply `lane_mask` |
| mask_zero | input | 1 | Unselected lanes: 0 = keep old value, 1 = write zero |
| upper_clear | input | 1 | Bits above the active length: 0 = keep, 1 = clear |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 512 | Registered result vector |

## Verification
The bench builds the unit with its default parameters: a 64-bit minimum length and four length steps. These give a 512-bit datapath, a 64-bit mask and a 2-bit length select, so every length, both lane sizes and every mask bit are reachable. The full mask makes it possible to set bits above the active lane count and show that they do nothing. The 512-bit width leaves room above each shorter length to observe both the keep and the clear behaviour. The 16-bit pairing of byte lanes exposes any borrow that leaks between neighbouring bytes.

// File: rtl/usub_pkg.sv
// Package: shared control type and helpers for the saturating subtractor.
// Assumes lengths grow by powers of two from a minimum length in bits.
package usub_pkg;

    // Normalized per-operation control, after illegal combinations are folded.
    typedef struct packed {
        logic word;         // 16-bit lanes when set
        logic use_mask;     // mask bits are honoured
        logic zero_mode;    // unselected lanes are cleared instead of merged
        logic clear_upper;  // bits above the active length are cleared
    } usub_ctrl_t;

    // Number of active bytes for a length select value.
    function automatic int unsigned active_bytes(input int unsigned min_vl,
                                                 input int unsigned vsel);
        return (min_vl / 8) << vsel;
    endfunction

endpackage

// File: rtl/usub_slice.sv
// Module: one 16-bit slice of the subtractor datapath.
// It computes either two independent byte differences or one word difference,
// clamping negative results to zero. The byte-to-byte borrow is passed only
// in word mode, so byte lanes stay isolated.
module usub_slice (
    input  logic        word,
    input  logic [15:0] a,
    input  logic [15:0] b,
    output logic [15:0] sat
);
    logic [8:0] lo_diff;
    logic [8:0] hi_diff;
    logic       lo_borrow;
    logic       hi_borrow;
    logic       lo_neg;

    // Low byte difference and the borrow it generates.
    always_comb begin
        lo_diff   = {1'b0, a[7:0]} - {1'b0, b[7:0]};
        lo_borrow = lo_diff[8];
    end

    // High byte difference, chained to the low byte only for word lanes.
    always_comb begin
        hi_diff   = {1'b0, a[15:8]} - {1'b0, b[15:8]} - {8'd0, (word & lo_borrow)};
        hi_borrow = hi_diff[8];
    end

    // Clamp: a word lane is negative when the chained borrow leaves the top.
    always_comb begin
        lo_neg     = word ? hi_borrow : lo_borrow;
        sat[7:0]   = lo_neg    ? 8'h00 : lo_diff[7:0];
        sat[15:8]  = hi_borrow ? 8'h00 : hi_diff[7:0];
    end
endmodule

// File: rtl/usub_lane_ctrl.sv
// Module: output select for one byte of the destination.
// It chooses the saturated difference, the old destination byte or zero from
// the mask, the merge/zero mode and the position against the active length.
// Assumes the control is already normalized (no masking at minimum length).
module usub_lane_ctrl
    import usub_pkg::*;
#(
    parameter int BYTE_IDX = 0,
    parameter int MASK_W   = 64,
    parameter int VSEL_W   = 2,
    parameter int MIN_VL   = 64
) (
    input  logic [7:0]        diff_byte,
    input  logic [7:0]        old_byte,
    input  logic [MASK_W-1:0] lane_mask,
    input  logic [VSEL_W-1:0] vlen_sel,
    input  usub_ctrl_t        ctrl,
    output logic [7:0]        out_byte
);
    localparam int LANE_B = BYTE_IDX;
    localparam int LANE_W = BYTE_IDX / 2;

    logic active;
    logic sel_bit;

    // Does this byte fall inside the active vector length?
    always_comb active = (BYTE_IDX < active_bytes(MIN_VL, 32'(vlen_sel)));

    // Mask bit that governs the lane holding this byte.
    always_comb sel_bit = ctrl.word ? lane_mask[LANE_W] : lane_mask[LANE_B];

    // Final byte choice.
    always_comb begin
        if (active) begin
            if (!ctrl.use_mask || sel_bit) out_byte = diff_byte;
            else if (ctrl.zero_mode)       out_byte = 8'h00;
            else                           out_byte = old_byte;
        end else begin
            out_byte = ctrl.clear_upper ? 8'h00 : old_byte;
        end
    end
endmodule

// File: rtl/packed_usub_sat.sv
// Module: masked packed unsigned saturating subtractor, top level.
// It subtracts src_b from src_a per lane, applies merge or zero masking and the
// upper-bit policy, and registers the full vector with a one-cycle strobe.
// Assumes synchronous active-low reset; the minimum length folds masking off
// and keeps upper bits.
module packed_usub_sat
    import usub_pkg::*;
#(
    parameter  int MIN_VL = 64,
    parameter  int NUM_VL = 4,
    localparam int MAX_W  = MIN_VL << (NUM_VL - 1),
    localparam int MASK_W = MAX_W / 8,
    localparam int VSEL_W = $clog2(NUM_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MAX_W-1:0]  src_a,
    input  logic [MAX_W-1:0]  src_b,
    input  logic [MAX_W-1:0]  dest_old,
    input  logic [MASK_W-1:0] lane_mask,
    input  logic              word_lanes,
    input  logic [VSEL_W-1:0] vlen_sel,
    input  logic              mask_en,
    input  logic              mask_zero,
    input  logic              upper_clear,
    output logic              out_valid,
    output logic [MAX_W-1:0]  result
);
    localparam int NUM_SLICE = MAX_W / 16;
    localparam int NUM_BYTE  = MAX_W / 8;

    usub_ctrl_t       ctrl;
    logic [MAX_W-1:0] diff_vec;
    logic [MAX_W-1:0] next_vec;
    logic             narrow;

    // Fold the minimum length into unmasked, upper-preserving operation.
    always_comb begin
        narrow           = (vlen_sel == '0);
        ctrl.word        = word_lanes;
        ctrl.use_mask    = mask_en & ~narrow;
        ctrl.zero_mode   = mask_zero;
        ctrl.clear_upper = upper_clear & ~narrow;
    end

    // Saturating difference for every 16-bit slice.
    for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
        usub_slice u_slice (
            .word (word_lanes),
            .a    (src_a[s*16 +: 16]),
            .b    (src_b[s*16 +: 16]),
            .sat  (diff_vec[s*16 +: 16])
        );
    end

    // Per-byte masking and upper-bit policy.
    for (genvar k = 0; k < NUM_BYTE; k++) begin : g_byte
        usub_lane_ctrl #(
            .BYTE_IDX (k),
            .MASK_W   (MASK_W),
            .VSEL_W   (VSEL_W),
            .MIN_VL   (MIN_VL)
        ) u_ctrl (
            .diff_byte (diff_vec[k*8 +: 8]),
            .old_byte  (dest_old[k*8 +: 8]),
            .lane_mask (lane_mask),
            .vlen_sel  (vlen_sel),
            .ctrl      (ctrl),
            .out_byte  (next_vec[k*8 +: 8])
        );
    end

    // Output register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_vec;
        end
    end
endmodule

// File: rtl/usub_checker.sv
// Module: property checker for packed_usub_sat, attached by bind.
// Observes ports only; assumes the default 2-bit length select encoding.
module usub_checker #(
    parameter int MAX_W  = 512,
    parameter int MASK_W = 64,
    parameter int VSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [MAX_W-1:0]  src_a,
    input logic [MAX_W-1:0]  src_b,
    input logic [MAX_W-1:0]  dest_old,
    input logic [MASK_W-1:0] lane_mask,
    input logic              word_lanes,
    input logic [VSEL_W-1:0] vlen_sel,
    input logic              mask_en,
    input logic              mask_zero,
    input logic              upper_clear,
    input logic              out_valid,
    input logic [MAX_W-1:0]  result
);
    // R1: byte lane 0 clamps to zero on a negative difference when selected.
    assert_byte_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !word_lanes && (src_a[7:0] < src_b[7:0]) &&
         (!mask_en || vlen_sel == '0 || lane_mask[0]))
        |=> (result[7:0] == 8'h00));

    // R2: word lane 0 clamps to zero on a negative difference when selected.
    assert_word_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && word_lanes && (src_a[15:0] < src_b[15:0]) &&
         (!mask_en || vlen_sel == '0 || lane_mask[0]))
        |=> (result[15:0] == 16'h0000));

    // R6: zeroing an unselected lane 0.
    assert_zero_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel != '0 && mask_en && mask_zero && !lane_mask[0])
        |=> (result[7:0] == 8'h00));

    // R5: merging an unselected lane 0.
    assert_merge_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel != '0 && mask_en && !mask_zero && !lane_mask[0])
        |=> (result[7:0] == $past(dest_old[7:0])));

    // R8: minimum length keeps every bit above 63.
    assert_narrow_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == '0)
        |=> (result[MAX_W-1:64] == $past(dest_old[MAX_W-1:64])));

    // R7: 128-bit length with clearing zeroes everything above bit 127.
    assert_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'd1 && upper_clear)
        |=> (result[MAX_W-1:128] == '0));

    // R10: strobe follows the capture cycle.
    assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: no strobe and a held result without a capture.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R10: reset clears the outputs.
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

bind packed_usub_sat usub_checker #(
    .MAX_W  (MAX_W),
    .MASK_W (MASK_W),
    .VSEL_W (VSEL_W)
) u_usub_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_a       (src_a),
    .src_b       (src_b),
    .dest_old    (dest_old),
    .lane_mask   (lane_mask),
    .word_lanes  (word_lanes),
    .vlen_sel    (vlen_sel),
    .mask_en     (mask_en),
    .mask_zero   (mask_zero),
    .upper_clear (upper_clear),
    .out_valid   (out_valid),
    .result      (result)
);

// File: tb/test_packed_usub_sat.sv
// Bench for packed_usub_sat: table walk, random sweep against a model built
// from the requirements, then directed reset and timing tests.
module test_packed_usub_sat;
    localparam int W  = 512;
    localparam int MW = 64;

    typedef struct packed {
        logic [15:0] a_pat;
        logic [15:0] b_pat;
        logic [15:0] o_pat;
        logic [63:0] mask;
        logic        word;
        logic [1:0]  vlen;
        logic        men;
        logic        mz;
        logic        uclr;
        logic [15:0] exp_lo;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TABLE [NV] = '{
        '{16'h1234, 16'h0510, 16'h0000, 64'h0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 16'h0D24}, // R1 plain
        '{16'h0000, 16'h0102, 16'hFFFF, 64'h0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1 zero minuend
        '{16'hABCD, 16'hABCD, 16'h1111, 64'h0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 equal
        '{16'h1010, 16'h2020, 16'h7777, 64'h0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 16'h0000}, // R1 b>a all
        '{16'h0100, 16'h0001, 16'h0000, 64'h0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 16'h0100}, // R2 byte no borrow
        '{16'h0100, 16'h0001, 16'h0000, 64'h0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 16'h00FF}, // R2 word borrow
        '{16'h1000, 16'h2000, 16'h0000, 64'h0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 word clamp
        '{16'h3030, 16'h1010, 16'h5A5A, 64'h0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 16'h5A5A}, // R5 merge
        '{16'h3030, 16'h1010, 16'h5A5A, 64'h0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0000}, // R6 zero
        '{16'h3030, 16'h1010, 16'hEEEE, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 16'h20EE}, // R4 alt
        '{16'h9000, 16'h1000, 16'hEEEE, 64'h5555_5555_5555_5555, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 16'h8000}, // R4 word
        '{16'h0F0F, 16'h0101, 16'hC3C3, 64'h0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 16'h0E0E}, // R8 narrow
        '{16'h0F0F, 16'h0101, 16'hC3C3, 64'h0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 16'h0E0E}, // R7 clear
        '{16'h4444, 16'h1111, 16'h3C3C, 64'hFFFF_FFFF_FFFF_0000, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 16'h3C3C}  // R9 high mask
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  src_a = '0;
    logic [W-1:0]  src_b = '0;
    logic [W-1:0]  dest_old = '0;
    logic [MW-1:0] lane_mask = '0;
    logic          word_lanes = 1'b0;
    logic [1:0]    vlen_sel = 2'd0;
    logic          mask_en = 1'b0;
    logic          mask_zero = 1'b0;
    logic          upper_clear = 1'b0;
    logic          out_valid;
    logic [W-1:0]  result;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    packed_usub_sat i_packed_usub_sat (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .src_a       (src_a),
        .src_b       (src_b),
        .dest_old    (dest_old),
        .lane_mask   (lane_mask),
        .word_lanes  (word_lanes),
        .vlen_sel    (vlen_sel),
        .mask_en     (mask_en),
        .mask_zero   (mask_zero),
        .upper_clear (upper_clear),
        .out_valid   (out_valid),
        .result      (result)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Requirement model: per-lane clamp, mask policy, upper-bit policy.
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] o, input logic [MW-1:0] m,
                                           input logic w, input logic [1:0] v,
                                           input logic me, input logic mz, input logic uc);
        logic [W-1:0] r;
        int  vl;
        bit  use_m;
        bit  clr;
        vl    = 64 << v;
        use_m = me && (v != 2'd0);
        clr   = uc && (v != 2'd0);
        r     = '0;
        if (!w) begin
            for (int j = 0; j < W/8; j++) begin
                logic [7:0] x;
                logic [7:0] y;
                logic [7:0] d;
                x = a[j*8 +: 8];
                y = b[j*8 +: 8];
                d = (x >= y) ? (x - y) : 8'h00;
                if (j*8 < vl) r[j*8 +: 8] = (!use_m || m[j]) ? d : (mz ? 8'h00 : o[j*8 +: 8]);
                else          r[j*8 +: 8] = clr ? 8'h00 : o[j*8 +: 8];
            end
        end else begin
            for (int j = 0; j < W/16; j++) begin
                logic [15:0] x;
                logic [15:0] y;
                logic [15:0] d;
                x = a[j*16 +: 16];
                y = b[j*16 +: 16];
                d = (x >= y) ? (x - y) : 16'h0000;
                if (j*16 < vl) r[j*16 +: 16] = (!use_m || m[j]) ? d : (mz ? 16'h0000 : o[j*16 +: 16]);
                else           r[j*16 +: 16] = clr ? 16'h0000 : o[j*16 +: 16];
            end
        end
        return r;
    endfunction

    // Drive one operation and compare the registered result one edge later.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] o, input logic [MW-1:0] m,
                          input logic w, input logic [1:0] v, input logic me,
                          input logic mz, input logic uc, input string req);
        logic [W-1:0] exp;
        exp = model(a, b, o, m, w, v, me, mz, uc);
        @(negedge clk);
        src_a = a; src_b = b; dest_old = o; lane_mask = m; word_lanes = w;
        vlen_sel = v; mask_en = me; mask_zero = mz; upper_clear = uc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R10 strobe", W'(out_valid), W'(1));
        chk(result == exp, req, result, exp);
    endtask

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] r;
        for (int i = 0; i < W/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [W-1:0] held;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 reset out_valid", W'(out_valid), '0);
        chk(result == '0, "R10 reset result", result, '0);
        rst_n = 1'b1;

        // Table walk (R1..R9), with the hand-computed low word as a second check
        for (int t = 0; t < NV; t++) begin
            run_op({32{TABLE[t].a_pat}}, {32{TABLE[t].b_pat}}, {32{TABLE[t].o_pat}},
                   TABLE[t].mask, TABLE[t].word, TABLE[t].vlen, TABLE[t].men,
                   TABLE[t].mz, TABLE[t].uclr, "R3 table full vector");
            chk(result[15:0] == TABLE[t].exp_lo, "R4 table low lane", W'(result[15:0]),
                W'(TABLE[t].exp_lo));
        end

        // R9: same operation with only lanes above the count differing in the mask
        run_op({32{16'h4444}}, {32{16'h1111}}, {32{16'h3C3C}}, 64'h0000_0000_0000_FFFF,
               1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R9 mask low only");
        held = result;
        run_op({32{16'h4444}}, {32{16'h1111}}, {32{16'h3C3C}}, 64'hFFFF_FFFF_FFFF_FFFF,
               1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R9 mask high set");
        chk(result == held, "R9 high mask bits ignored", result, held);

        // R8: narrow length with every control toggled gives the plain result
        run_op(rnd_vec(), rnd_vec(), rnd_vec(), 64'h0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1,
               "R8 narrow word");

        // R10: hold and strobe low while idle
        held = result;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 strobe low idle", W'(out_valid), '0);
        src_a = rnd_vec(); src_b = rnd_vec(); dest_old = rnd_vec();
        @(negedge clk);
        chk(result == held, "R10 result held", result, held);

        // Random sweep (R1..R9)
        for (int n = 0; n < 300; n++) begin
            logic [MW-1:0] m;
            m = {$urandom, $urandom};
            run_op(rnd_vec(), rnd_vec(), rnd_vec(), m, 1'($urandom), 2'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), "R7 random vector");
        end

        // R10: reset wins over a capture in the same cycle
        @(negedge clk);
        src_a = {W{1'b1}}; src_b = '0; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R10 reset with capture out_valid", W'(out_valid), '0);
        chk(result == '0, "R10 reset with capture result", result, '0);
        rst_n = 1'b1;
        run_op({W{1'b1}}, '0, '0, 64'h0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, "R1 after reset");

        summary();
    end
endmodule